// File: doc/BRIEF.md
# Dual-Device Console Serial Controller

This block is the serial link between the processor and its console terminal. The link has two halves, and each half answers to its own programmed-I/O device code. The receive device turns the incoming line into 8-bit characters and holds each finished character until the processor reads it with an input command. The transmit device takes one 8-bit character from an output command and sends it out on the line. The two devices keep separate flags and do not wait on each other, so one character can arrive while another is being sent.

Every character travels as a frame. The frame is one low start bit, then eight data bits with the least significant bit first, then one high stop bit. The line rests high between frames, and no parity bit is added or checked. A 4-bit rate field picks one of sixteen bit rates. Each device reads the field when a character begins and holds that value until the character ends. A change to the field therefore takes effect from the next character.

Top module: `dual_serial_ctrl`

## Requirements
- R1: After reset, `tx_line` is high, `tx_busy`, `tx_done`, `rx_done` and `rx_overrun` are low, and `pio_rdata` is zero.
- R2: A transmitted frame is a low start bit, the 8 data bits with bit 0 first, then a high stop bit. Each bit lasts 16*BASE_DIV*(rate_sel+1) clock cycles.
- R3: An output command to device code TX_CODE (default 11) while the transmitter is idle sets `tx_busy` at the next clock edge and clears `tx_done`. `tx_busy` falls 160*BASE_DIV*(rate_sel+1) cycles after that edge, and `tx_done` rises on the same edge.
- R4: An output command to TX_CODE while `tx_busy` is high is ignored. The frame in progress is unchanged and no second frame follows it.
- R5: The receiver samples `rx_line` at 16 times the bit rate and reads each bit at its centre. After a good stop bit it places the character in its holding register and raises `rx_done`. An input command to RX_CODE (default 10) returns that character on `pio_rdata` in the same cycle.
- R6: An input command to RX_CODE clears `rx_done` and `rx_overrun` at the next clock edge, unless a new character completes on that edge.
- R7: If a character completes while `rx_done` is still high, `rx_overrun` is set and the newest character replaces the held one.
- R8: A low pulse on `rx_line` that is over before the middle of a start bit is rejected and yields no character.
- R9: A change of `rate_sel` during a character does not disturb that character. The next character uses the new rate, on both the transmit side and the receive side.
- R10: The two devices are independent. Commands to any other device code have no effect. An input command to TX_CODE returns zero and leaves `rx_done` unchanged. Receiving and transmitting can run at the same time.
- R11: A frame whose stop bit samples low is discarded: the holding register and `rx_done` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pio_wr | input | 1 | Output-command strobe, one cycle |
| pio_rd | input | 1 | Input-command strobe, one cycle |
| pio_dev | input | DEV_W | Device code of the command |
| pio_wdata | input | 8 | Character to transmit |
| rate_sel | input | 4 | Bit-rate select field |
| pio_rdata | output | 8 | Received character during an input command to RX_CODE, else zero |
| rx_line | input | 1 | Serial input, idles high |
| tx_line | output | 1 | Serial output, idles high |
| rx_done | output | 1 | Receive device holds an unread character |
| rx_overrun | output | 1 | A character arrived while the previous one was unread |
| tx_busy | output | 1 | Transmit device is sending a frame |
| tx_done | output | 1 | Transmit device finished its last frame |

## Verification
A wrong sub-bit or bit counter shows on `tx_line` as a bit whose centre holds the wrong level. It also shows as a `tx_busy` fall that is early or late by whole tick periods. Both can be seen within one frame of the faulty write. On the receive side, a bad sampling phase or bad shift order gives a wrong character at the next input command. Bad flag logic shows as `rx_done` or `rx_overrun` at the wrong level right after the read or second arrival that should have changed it. A device that latched the rate at the wrong moment garbles the character during which `rate_sel` moved.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } dsc_rx_state_e;

    localparam int unsigned OVERSAMPLE = 16;
    localparam int unsigned CHAR_BITS  = 8;

endpackage

// File: rtl/dsc_tick_gen.sv
module dsc_tick_gen #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          en,
    input  logic [CW-1:0] div,
    output logic          tick
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_state_t;

    tick_state_t st_d, st_q;
    logic        at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.cnt == div - CW'(1));
        tick   = en && !restart && at_end;
        if (restart) begin
            st_d.cnt = '0;
        end else if (en) begin
            st_d.cnt = at_end ? '0 : st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_tick_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !restart) |-> (st_q.cnt < div));

endmodule

// File: rtl/dsc_tx_unit.sv
module dsc_tx_unit #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [7:0]       wdata,
    input  logic [DIV_W-1:0] div_in,
    output logic             line,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic             line;
        logic [7:0]       data;
        logic [3:0]       sub;
        logic [3:0]       bitn;
        logic [DIV_W-1:0] div;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      accept;
    logic      tick;

    dsc_tick_gen #(.CW(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .en      (st_q.busy),
        .div     (st_q.div),
        .tick    (tick)
    );

    always_comb begin
        st_d   = st_q;
        accept = wr_hit && !st_q.busy;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.done = 1'b0;
            st_d.line = 1'b0;
            st_d.data = wdata;
            st_d.sub  = '0;
            st_d.bitn = '0;
            st_d.div  = div_in;
        end else if (st_q.busy && tick) begin
            if (st_q.sub == 4'd15) begin
                st_d.sub = '0;
                if (st_q.bitn == 4'd9) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    st_d.line = 1'b1;
                end else begin
                    st_d.bitn = st_q.bitn + 4'd1;
                    st_d.line = (st_q.bitn == 4'd8) ? 1'b1 : st_q.data[st_q.bitn[2:0]];
                end
            end else begin
                st_d.sub = st_q.sub + 4'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.line <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign line = st_q.line;
    assign busy = st_q.busy;
    assign done = st_q.done;

    assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> st_q.line);
    assert_frame_opens_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> !st_q.line);
    assert_done_on_busy_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> st_q.done);
    assert_busy_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && wr_hit) |=> $stable(st_q.data));

endmodule

// File: rtl/dsc_rx_unit.sv
module dsc_rx_unit
    import dsc_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             rd_hit,
    input  logic [DIV_W-1:0] div_in,
    output logic [7:0]       hold,
    output logic             done,
    output logic             overrun
);
    typedef struct packed {
        dsc_rx_state_e    st;
        logic             s1;
        logic             s2;
        logic [3:0]       sub;
        logic [2:0]       bitn;
        logic [7:0]       shreg;
        logic [7:0]       hold;
        logic             done;
        logic             ovr;
        logic [DIV_W-1:0] div;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      deliver;
    logic      restart;
    logic      tick;

    assign restart = (st_q.st == RX_IDLE) && !st_q.s2;

    dsc_tick_gen #(.CW(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .en      (st_q.st != RX_IDLE),
        .div     (st_q.div),
        .tick    (tick)
    );

    always_comb begin
        st_d    = st_q;
        deliver = 1'b0;
        st_d.s1 = line_in;
        st_d.s2 = st_q.s1;
        case (st_q.st)
            RX_IDLE: begin
                if (!st_q.s2) begin
                    st_d.st  = RX_START;
                    st_d.sub = '0;
                    st_d.div = div_in;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (st_q.sub == 4'd7) begin
                        st_d.sub  = '0;
                        st_d.bitn = '0;
                        st_d.st   = st_q.s2 ? RX_IDLE : RX_DATA;
                    end else begin
                        st_d.sub = st_q.sub + 4'd1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (st_q.sub == 4'd15) begin
                        st_d.sub   = '0;
                        st_d.shreg = {st_q.s2, st_q.shreg[7:1]};
                        if (st_q.bitn == 3'd7) st_d.st = RX_STOP;
                        else                   st_d.bitn = st_q.bitn + 3'd1;
                    end else begin
                        st_d.sub = st_q.sub + 4'd1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (st_q.sub == 4'd15) begin
                        st_d.st = RX_IDLE;
                        deliver = st_q.s2;
                    end else begin
                        st_d.sub = st_q.sub + 4'd1;
                    end
                end
            end
        endcase

        if (deliver) begin
            st_d.hold = st_q.shreg;
            st_d.done = 1'b1;
            st_d.ovr  = rd_hit ? 1'b0 : (st_q.ovr || st_q.done);
        end else if (rd_hit) begin
            st_d.done = 1'b0;
            st_d.ovr  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.st <= RX_IDLE;
            st_q.s1 <= 1'b1;
            st_q.s2 <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold    = st_q.hold;
    assign done    = st_q.done;
    assign overrun = st_q.ovr;

    assert_read_clears_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !deliver) |=> (!st_q.done && !st_q.ovr));
    assert_overrun_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovr) |-> $past(st_q.done));
    assert_overrun_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovr |-> st_q.done);
    assert_hold_only_on_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !deliver |=> $stable(st_q.hold));

endmodule

// File: rtl/dual_serial_ctrl.sv
module dual_serial_ctrl #(
    parameter int unsigned BASE_DIV = 2,
    parameter int unsigned DEV_W    = 6,
    parameter int unsigned RX_CODE  = 10,
    parameter int unsigned TX_CODE  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pio_wr,
    input  logic             pio_rd,
    input  logic [DEV_W-1:0] pio_dev,
    input  logic [7:0]       pio_wdata,
    input  logic [3:0]       rate_sel,
    output logic [7:0]       pio_rdata,
    input  logic             rx_line,
    output logic             tx_line,
    output logic             rx_done,
    output logic             rx_overrun,
    output logic             tx_busy,
    output logic             tx_done
);
    localparam int unsigned DIV_W = $clog2(BASE_DIV * 16 + 1);

    logic [DIV_W-1:0] rate_div;
    logic             rx_sel;
    logic             tx_sel;
    logic [7:0]       rx_hold;

    assign rate_div = DIV_W'(BASE_DIV * (int'(rate_sel) + 1));
    assign rx_sel   = (pio_dev == DEV_W'(RX_CODE));
    assign tx_sel   = (pio_dev == DEV_W'(TX_CODE));

    dsc_rx_unit #(.DIV_W(DIV_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (rx_line),
        .rd_hit  (pio_rd && rx_sel),
        .div_in  (rate_div),
        .hold    (rx_hold),
        .done    (rx_done),
        .overrun (rx_overrun)
    );

    dsc_tx_unit #(.DIV_W(DIV_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (pio_wr && tx_sel),
        .wdata  (pio_wdata),
        .div_in (rate_div),
        .line   (tx_line),
        .busy   (tx_busy),
        .done   (tx_done)
    );

    assign pio_rdata = (pio_rd && rx_sel) ? rx_hold : 8'h00;

    assert_busy_done_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_busy && tx_done));

endmodule

// File: tb/dual_serial_ctrl_tb.sv
module dual_serial_ctrl_tb;
    localparam int BASE = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pio_wr, pio_rd;
    logic [5:0] pio_dev;
    logic [7:0] pio_wdata;
    logic [3:0] rate_sel;
    logic [7:0] pio_rdata;
    logic       rx_line, tx_line, rx_done, rx_overrun, tx_busy, tx_done;

    int errs   = 0;
    int checks = 0;
    int tx_div_cur = BASE;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #10 clk = ~clk;

    dual_serial_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pio_wr(pio_wr), .pio_rd(pio_rd),
        .pio_dev(pio_dev), .pio_wdata(pio_wdata), .rate_sel(rate_sel),
        .pio_rdata(pio_rdata), .rx_line(rx_line), .tx_line(tx_line),
        .rx_done(rx_done), .rx_overrun(rx_overrun), .tx_busy(tx_busy),
        .tx_done(tx_done)
    );

    function automatic int divof(input int sel);
        return BASE * (sel + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pio_write(input logic [5:0] dev, input logic [7:0] d);
        @(negedge clk);
        pio_wr = 1'b1; pio_dev = dev; pio_wdata = d;
        @(negedge clk);
        pio_wr = 1'b0;
    endtask

    task automatic pio_read(input logic [5:0] dev, output logic [7:0] v);
        @(negedge clk);
        pio_rd = 1'b1; pio_dev = dev;
        #1 v = pio_rdata;
        @(negedge clk);
        pio_rd = 1'b0;
    endtask

    // driver: queue expected character, then start the frame
    task automatic tx_send(input logic [7:0] d);
        txq.push_back(d);
        tx_div_cur = divof(int'(rate_sel));
        pio_write(6'd11, d);
    endtask

    task automatic rx_frame(input logic [7:0] d, input int sel, input logic stop);
        int bt;
        bt = 16 * divof(sel);
        @(negedge clk);
        rx_line = 1'b0;
        repeat (bt) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = d[i];
            repeat (bt) @(negedge clk);
        end
        rx_line = stop;
        repeat (bt) @(negedge clk);
        rx_line = 1'b1;
    endtask

    task automatic rx_send(input logic [7:0] d, input int sel);
        rxq.push_back(d);
        rx_frame(d, sel, 1'b1);
    endtask

    task automatic rx_check(input string req);
        logic [7:0] v, e;
        chk(rx_done === 1'b1, {req, " done"}, rx_done, 1);
        pio_read(6'd10, v);
        e = (rxq.size() > 0) ? rxq.pop_front() : 8'hxx;
        chk(v === e, req, v, e);
        chk(rx_done === 1'b0, "R6 done cleared", rx_done, 0);
    endtask

    // monitor: decode every frame on tx_line and compare with the queue
    initial begin
        int d;
        logic [7:0] got;
        logic ok;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && tx_line === 1'b0) begin
                d = tx_div_cur;
                ok = 1'b1;
                repeat (8 * d) @(negedge clk);
                if (tx_line !== 1'b0) ok = 1'b0;
                for (int i = 0; i < 8; i++) begin
                    repeat (16 * d) @(negedge clk);
                    got[i] = tx_line;
                end
                repeat (16 * d) @(negedge clk);
                if (tx_line !== 1'b1) ok = 1'b0;
                if (txq.size() == 0) begin
                    chk(1'b0, "R4 unexpected frame", got, 0);
                end else begin
                    logic [7:0] e;
                    e = txq.pop_front();
                    chk(ok, "R2 start/stop levels", ok, 1);
                    chk(got === e, "R2 frame data", got, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int d;
        rst_n = 1'b0; pio_wr = 1'b0; pio_rd = 1'b0; pio_dev = '0;
        pio_wdata = '0; rate_sel = 4'd0; rx_line = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(tx_line === 1'b1, "R1 tx_line", tx_line, 1);
        chk(tx_busy === 1'b0, "R1 tx_busy", tx_busy, 0);
        chk(tx_done === 1'b0, "R1 tx_done", tx_done, 0);
        chk(rx_done === 1'b0, "R1 rx_done", rx_done, 0);
        chk(rx_overrun === 1'b0, "R1 rx_overrun", rx_overrun, 0);
        chk(pio_rdata === 8'h00, "R1 rdata", pio_rdata, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3 busy timing at rate 0
        d = divof(0);
        tx_send(8'hA5);
        chk(tx_busy === 1'b1, "R3 busy rises", tx_busy, 1);
        repeat (160 * d - 1) @(negedge clk);
        chk(tx_busy === 1'b1, "R3 busy before end", tx_busy, 1);
        @(negedge clk);
        chk(tx_busy === 1'b0, "R3 busy falls", tx_busy, 0);
        chk(tx_done === 1'b1, "R3 done rises", tx_done, 1);

        // R4 write while busy is ignored
        rate_sel = 4'd3;
        tx_send(8'h3C);
        chk(tx_done === 1'b0, "R3 done cleared on write", tx_done, 0);
        repeat (40) @(negedge clk);
        pio_write(6'd11, 8'hFF);
        chk(tx_busy === 1'b1, "R4 still busy", tx_busy, 1);
        while (tx_busy) @(negedge clk);
        repeat (300) @(negedge clk);
        chk(tx_busy === 1'b0 && tx_line === 1'b1, "R4 no second frame", tx_busy, 0);

        // R9 tx rate change mid-character
        tx_send(8'h81);
        repeat (100) @(negedge clk);
        rate_sel = 4'd0;
        while (tx_busy) @(negedge clk);
        repeat (4) @(negedge clk);
        tx_send(8'h5E);
        while (tx_busy) @(negedge clk);
        repeat (4) @(negedge clk);

        // R5 receive at two rates
        rx_send(8'h96, 0);
        rx_check("R5 rx 0x96 rate0");
        rate_sel = 4'd15;
        rx_send(8'h01, 15);
        rx_check("R5 rx 0x01 rate15");
        rate_sel = 4'd0;

        // R7 overrun
        rx_frame(8'h11, 0, 1'b1);
        rxq.push_back(8'h22);
        rx_frame(8'h22, 0, 1'b1);
        chk(rx_overrun === 1'b1, "R7 overrun set", rx_overrun, 1);
        rx_check("R7 newest kept");
        chk(rx_overrun === 1'b0, "R6 overrun cleared", rx_overrun, 0);

        // R8 short start glitch
        @(negedge clk);
        rx_line = 1'b0;
        repeat (4 * divof(0)) @(negedge clk);
        rx_line = 1'b1;
        repeat (400) @(negedge clk);
        chk(rx_done === 1'b0, "R8 glitch rejected", rx_done, 0);
        rx_send(8'h7E, 0);
        rx_check("R8 next char ok");

        // R11 bad stop bit
        rx_frame(8'hF0, 0, 1'b0);
        repeat (100) @(negedge clk);
        chk(rx_done === 1'b0, "R11 bad stop discarded", rx_done, 0);

        // R9 rx rate change mid-character
        rate_sel = 4'd3;
        fork
            rx_send(8'hC3, 3);
            begin repeat (300) @(negedge clk); rate_sel = 4'd0; end
        join
        rx_check("R9 rx old rate");
        rx_send(8'h3A, 0);
        rx_check("R9 rx new rate");

        // R10 independence
        pio_write(6'd12, 8'h55);
        @(negedge clk);
        chk(tx_busy === 1'b0, "R10 other code write", tx_busy, 0);
        fork
            tx_send(8'h6D);
            rx_send(8'h4B, 0);
        join
        pio_read(6'd11, v);
        chk(v === 8'h00, "R10 read tx code", v, 0);
        chk(rx_done === 1'b1, "R10 done kept", rx_done, 1);
        pio_read(6'd12, v);
        chk(rx_done === 1'b1, "R10 other read", rx_done, 1);
        rx_check("R10 concurrent rx");
        while (tx_busy) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(txq.size() == 0, "R2 all frames seen", txq.size(), 0);

        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule